// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store request into a stream of byte addresses, one per element. Element 0 comes first and element vl-1 comes last. A request is launched with a single-cycle `start` pulse. At that pulse the block captures the addressing mode, the scalar base, the 7-bit immediate, the scalar stride, the element size code and the active vector length.

Three addressing modes are supported:
- **Contiguous mode:** elements sit back to back, and the region begins at an immediate offset scaled by the element size.
- **Constant-stride mode:** consecutive elements lie a signed byte distance apart.
- **Indexed mode (gather/scatter):** each element's offset arrives from the index vector on a separate ready/valid stream.

Each address leaves on a ready/valid beat that is tagged with its element number. A one-cycle `done` pulse closes the request. A request with a vector length of zero issues no beat and finishes at once. The downstream memory port consumes the beats at its own pace.

Top module: `vec_addr_gen`

## Requirements
- R1: Modes 0 and 3 (contiguous): beat i carries `base + (imm << es) + (i << es)`. The size code `es` of 0, 1, 2 or 3 selects 1, 2, 4 or 8 byte elements. All address arithmetic is modulo 2^AW.
- R2: Mode 1 (constant stride): beat i carries `base + i * stride`. The stride is a two's-complement value, so a negative stride gives descending addresses. The immediate has no effect in this mode.
- R3: Mode 2 (indexed): beat i carries `base + off_i`, where `off_i` is the i-th word taken from the index stream. The immediate and the stride have no effect. `out_valid` stays low while `idx_valid` is low. An index word is taken only in a cycle in which the address beat is accepted.
- R4: A request with vector length vl issues exactly vl accepted beats. Their `out_elem` values run 0, 1, ..., vl-1 in order.
- R5: In modes 0, 1 and 3, a beat that is offered but not accepted keeps `out_valid`, `out_addr` and `out_elem` unchanged in the next cycle.
- R6: `done` is high for exactly one cycle. That cycle directly follows the acceptance of beat vl-1, and no beat is offered while `done` is high.
- R7: A `start` with vl equal to 0 issues no beat, and `done` is high in the cycle after the `start`.
- R8: A `start` that arrives while a request is in progress is ignored. The running request keeps its captured settings and its element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a request (taken only when idle) |
| mode | input | 2 | 0/3 contiguous, 1 constant stride, 2 indexed |
| base | input | AW | Scalar base byte address |
| imm | input | 7 | Unsigned immediate in elements (contiguous mode) |
| stride | input | AW | Signed byte stride (constant-stride mode) |
| esize | input | 2 | log2 of the element size in bytes |
| vl | input | VLW | Number of elements to address |
| idx_valid | input | 1 | Index stream word present |
| idx_data | input | AW | Byte offset of the next element (indexed mode) |
| idx_ready | output | 1 | Index word is consumed when idx_valid is also high |
| out_valid | output | 1 | Address beat offered |
| out_addr | output | AW | Byte address of the element |
| out_elem | output | VLW | Element number of the beat |
| out_ready | input | 1 | Consumer accepts the beat |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The embedded properties run on every cycle and check the protocol:
- a held beat stays stable while it waits;
- element numbers step by one and stay below the captured length;
- an index word is taken only together with an address beat;
- `done` is a single pulse that never overlaps a beat;
- a zero-length launch gives an immediate `done`.

Only the directed scenarios can show that the address values themselves are right in each mode. They also cover immediate scaling, negative strides, wrap-around, the exact beat count and the rejection of a second `start`.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    VAG_UNIT     = 2'd0,
    VAG_STRIDED  = 2'd1,
    VAG_INDEXED  = 2'd2,
    VAG_UNIT_ALT = 2'd3
  } vag_mode_e;

  // Left shift by the element-size code: x * (1 << es).
  function automatic logic [63:0] vag_scale(input logic [63:0] x, input logic [1:0] es);
    return x << es;
  endfunction

  // Address accumulator start value for the non-indexed modes.
  function automatic logic [63:0] vag_first(input logic [63:0] base, input logic [6:0] imm,
                                            input logic [1:0] es, input logic strided);
    return strided ? base : base + vag_scale(64'(imm), es);
  endfunction

  // Per-element increment for the non-indexed modes.
  function automatic logic [63:0] vag_step(input logic [63:0] stride, input logic [1:0] es,
                                           input logic strided);
    return strided ? stride : vag_scale(64'd1, es);
  endfunction

endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl #(
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic           beat_fire,
  output logic           busy,
  output logic           launch,
  output logic           zero_start,
  output logic           last_beat,
  output logic [VLW-1:0] elem,
  output logic [VLW-1:0] cfg_vl,
  output logic           done
);

  logic [VLW-1:0] elem_r;
  logic [VLW-1:0] vl_r;
  logic           busy_r;
  logic           done_r;

  assign launch     = start && !busy_r && (vl != '0);
  assign zero_start = start && !busy_r && (vl == '0);
  assign last_beat  = busy_r && (elem_r == vl_r - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      elem_r <= '0;
      vl_r   <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= (beat_fire && last_beat) || zero_start;
      if (launch) begin
        busy_r <= 1'b1;
        elem_r <= '0;
        vl_r   <= vl;
      end else if (beat_fire) begin
        if (last_beat) busy_r <= 1'b0;
        else           elem_r <= elem_r + 1'b1;
      end
    end
  end

  assign busy   = busy_r;
  assign elem   = elem_r;
  assign cfg_vl = vl_r;
  assign done   = done_r;

  // Element counter advances exactly on accepted non-final beats
  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !last_beat |=> elem == $past(elem) + 1'b1); // R4

endmodule

// File: rtl/vag_addr.sv
module vag_addr
  import vag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [6:0]    imm,
  input  logic [AW-1:0] stride,
  input  logic [1:0]    esize,
  input  logic          advance,
  input  logic [AW-1:0] idx_data,
  output logic          is_indexed,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] acc_r, step_r, base_r;
  logic          idx_r;
  logic          strided_in;
  logic [AW-1:0] first_w, step_w;

  assign strided_in = (vag_mode_e'(mode) == VAG_STRIDED);
  assign first_w    = AW'(vag_first(64'(base), imm, esize, strided_in));
  assign step_w     = AW'(vag_step(64'(stride), esize, strided_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r  <= '0;
      step_r <= '0;
      base_r <= '0;
      idx_r  <= 1'b0;
    end else if (load) begin
      acc_r  <= first_w;
      step_r <= step_w;
      base_r <= base;
      idx_r  <= (vag_mode_e'(mode) == VAG_INDEXED);
    end else if (advance) begin
      acc_r  <= acc_r + step_r;
    end
  end

  assign is_indexed = idx_r;
  assign addr       = idx_r ? base_r + idx_data : acc_r;

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int AW  = 32,
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  base,
  input  logic [6:0]     imm,
  input  logic [AW-1:0]  stride,
  input  logic [1:0]     esize,
  input  logic [VLW-1:0] vl,
  input  logic           idx_valid,
  input  logic [AW-1:0]  idx_data,
  output logic           idx_ready,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr,
  output logic [VLW-1:0] out_elem,
  input  logic           out_ready,
  output logic           done
);

  logic           busy, launch, zero_start, last_beat, beat_fire, is_indexed;
  logic [VLW-1:0] elem, cfg_vl;

  assign out_valid = busy && (!is_indexed || idx_valid);
  assign beat_fire = out_valid && out_ready;
  assign idx_ready = busy && is_indexed && out_ready;
  assign out_elem  = elem;

  vag_ctrl #(.VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .beat_fire(beat_fire),
    .busy(busy), .launch(launch), .zero_start(zero_start), .last_beat(last_beat),
    .elem(elem), .cfg_vl(cfg_vl), .done(done)
  );

  vag_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(launch), .mode(mode), .base(base), .imm(imm),
    .stride(stride), .esize(esize), .advance(beat_fire), .idx_data(idx_data),
    .is_indexed(is_indexed), .addr(out_addr)
  );

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !is_indexed |=>
      out_valid && $stable(out_addr) && $stable(out_elem)); // R5

  AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_elem < cfg_vl); // R4

  AST_IDX_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && idx_ready |-> beat_fire); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R6

  AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R6

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> done && !out_valid); // R7

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_fire |=> $stable(cfg_vl) && $stable(out_elem)); // R8

endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] base = '0;
  logic [6:0]  imm = '0;
  logic [31:0] stride = '0;
  logic [1:0]  esize = '0;
  logic [7:0]  vl = '0;
  logic        idx_valid = 1'b0;
  logic [31:0] idx_data = '0;
  logic        idx_ready, out_valid, out_ready, done;
  logic [31:0] out_addr;
  logic [7:0]  out_elem;

  int checks = 0;
  int fails = 0;
  logic [31:0] idx_mem [0:15];

  always #10 clk = ~clk;

  vec_addr_gen #(.AW(32), .VLW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base), .imm(imm),
    .stride(stride), .esize(esize), .vl(vl), .idx_valid(idx_valid), .idx_data(idx_data),
    .idx_ready(idx_ready), .out_valid(out_valid), .out_addr(out_addr), .out_elem(out_elem),
    .out_ready(out_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] md, input logic [31:0] b,
      input logic [6:0] im, input logic [31:0] st, input logic [1:0] es, input int i);
    longint a;
    int sz;
    sz = 1;
    for (int k = 0; k < es; k++) sz = sz * 2;
    if (md == 2'd1)      a = longint'(b) + longint'(i) * longint'($signed(st));
    else if (md == 2'd2) a = longint'(b) + longint'(idx_mem[i]);
    else                 a = longint'(b) + longint'(im) * sz + longint'(i) * sz;
    return a[31:0];
  endfunction

  task automatic run(input string nm, input logic [1:0] md, input logic [31:0] b,
                     input logic [6:0] im, input logic [31:0] st, input logic [1:0] es,
                     input int n, input bit stall, input bit poke);
    int got, ptr;
    bit prev_last, held, seen_done;
    logic [31:0] h_addr;
    logic [7:0]  h_elem;
    got = 0; ptr = 0; prev_last = 0; held = 0; seen_done = 0;
    h_addr = '0; h_elem = '0;
    @(negedge clk);
    mode = md; base = b; imm = im; stride = st; esize = es; vl = 8'(n); start = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 2) begin
        start = 1'b1; base = b ^ 32'h0001_0000; vl = 8'(n + 3); mode = 2'd1;
      end else begin
        base = b; vl = 8'(n); mode = md;
      end
      out_ready = stall ? ((c % 3) != 1) : 1'b1;
      idx_valid = (md == 2'd2) && ((c % 4) != 2) && (ptr < 16);
      idx_data  = idx_mem[ptr[3:0]];
      #1;
      if (held) begin
        chk(out_valid && out_addr == h_addr && out_elem == h_elem, {nm, " R5 hold"},
            longint'(out_addr), longint'(h_addr));
        held = 0;
      end
      if (done) begin
        chk(got == n, {nm, " R4 beat count"}, got, n);
        chk(prev_last || (n == 0 && c == 0), {nm, " R6/R7 done timing"}, c, got);
        chk(!out_valid, {nm, " R6 no beat with done"}, out_valid, 0);
        if (md == 2'd2) chk(ptr == n, {nm, " R3 index words used"}, ptr, n);
        seen_done = 1;
        break;
      end
      prev_last = 0;
      if (md == 2'd2 && !idx_valid)
        chk(!out_valid, {nm, " R3 wait for index"}, out_valid, 0);
      if (out_valid && out_ready) begin
        chk(out_elem == 8'(got), {nm, " R4 element number"}, out_elem, got);
        chk(out_addr == exp_addr(md, b, im, st, es, got), {nm, " R1/R2/R3 address"},
            longint'(out_addr), longint'(exp_addr(md, b, im, st, es, got)));
        got++;
        prev_last = (got == n);
      end else if (out_valid && md != 2'd2) begin
        held = 1; h_addr = out_addr; h_elem = out_elem;
      end
      if (idx_valid && idx_ready) ptr++;
    end
    if (!seen_done) chk(0, {nm, " R6 done never seen"}, 0, 1);
    @(negedge clk);
    idx_valid = 1'b0;
    #1;
    chk(!done, {nm, " R6 done single cycle"}, done, 0);
    chk(!out_valid, {nm, " R7/R4 idle after run"}, out_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) idx_mem[k] = 32'(k * 37 + ((k % 2) ? 32'hFFFF_FF00 : 0));
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !done && !idx_ready, "reset state R4/R6", {out_valid, done, idx_ready}, 0);
    rst_n = 1'b1;
    // R1 contiguous, 4-byte elements, immediate 3
    run("unit_w",   2'd0, 32'h0000_1000, 7'd3,   32'd0,       2'd2, 5, 0, 0);
    // R1 mode 3, byte elements, stalled consumer (R5)
    run("unit_b",   2'd3, 32'h0000_2001, 7'd10,  32'd0,       2'd0, 7, 1, 0);
    // R1 8-byte elements, largest immediate
    run("unit_d",   2'd0, 32'h0000_8000, 7'd127, 32'd0,       2'd3, 4, 1, 0);
    // R1 wrap-around modulo 2^32
    run("unit_wrap",2'd0, 32'hFFFF_FFF0, 7'd1,   32'd0,       2'd2, 6, 0, 0);
    // R2 positive stride with stalls
    run("stride_p", 2'd1, 32'h0000_4000, 7'd0,   32'd12,      2'd2, 6, 1, 0);
    // R2 negative stride, immediate must not matter
    run("stride_n", 2'd1, 32'h0000_4000, 7'd50,  32'hFFFF_FFF8, 2'd3, 5, 0, 0);
    // R3 indexed with gaps and stalls, immediate/stride must not matter
    run("indexed",  2'd2, 32'h1000_0000, 7'd9,   32'd100,     2'd1, 9, 1, 0);
    // R7 zero length in each mode
    run("zero_u",   2'd0, 32'h0000_0100, 7'd1,   32'd0,       2'd0, 0, 0, 0);
    run("zero_s",   2'd1, 32'h0000_0100, 7'd1,   32'd4,       2'd0, 0, 0, 0);
    run("zero_i",   2'd2, 32'h0000_0100, 7'd1,   32'd4,       2'd0, 0, 0, 0);
    // R4 single element
    run("one",      2'd1, 32'h0000_0700, 7'd0,   32'd64,      2'd0, 1, 1, 0);
    // R8 start during an active run is ignored
    run("restart",  2'd0, 32'h0000_3000, 7'd2,   32'd0,       2'd1, 8, 1, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule